// File: doc/BRIEF.md
# Dual-Mode Burst Address Sequencer

This block produces the word address for a four-beat memory burst. A start address is captured when either of two active-low address strobes is sampled low while the load-qualify input is high. The load-qualify input carries the result of chip-enable arbitration done outside the block. After the load, an active-low advance input steps the two low address bits through the burst. The upper address bits stay as they were loaded.

A static order-select input picks one of two beat orders. When it is high, beat k uses the loaded low bits XOR k, which gives the interleaved order. When it is low, beat k uses the loaded low bits plus k, modulo four, which gives a linear wrap order. The integrator ties order-select high when no choice is needed.

The output is registered and carries a two-bit kind flag. The flag tells whether the current address was just loaded, was advanced, was held, or whether no burst has started since reset.

Top module: `burst_addr_seq`

## Requirements
- R1: During and after reset, and until the first load, `addrOut` is 0 and `beatKind` is 0 (idle).
- R2: On a rising edge where `loadQualify` is 1 and `procStrobeN` or `ctrlStrobeN` is 0, the edge captures `addrIn`. After that edge, `addrOut` equals `addrIn` and `beatKind` is 1 (loaded).
- R3: A strobe sampled while `loadQualify` is 0 does not load. That edge behaves as though no strobe were present.
- R4: On a load edge, `advanceN` is ignored. The output shows the new start address, not a stepped address.
- R5: With `orderSel` at 1, beat k of the burst puts the loaded low two bits XOR k on `addrOut[1:0]`.
- R6: With `orderSel` at 0, beat k of the burst puts (loaded low two bits + k) mod 4 on `addrOut[1:0]`.
- R7: On a non-load edge during a burst with `advanceN` at 1, `addrOut` keeps its value and `beatKind` is 3 (held). On such an edge with `advanceN` at 0, the beat index moves on by one and `beatKind` is 2 (advanced).
- R8: `addrOut[ADDR_W-1:2]` changes only on a load. After the fourth beat, further advances cycle through the same group of four with no carry into the upper bits.
- R9: Before the first load, `advanceN` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| procStrobeN | input | 1 | First active-low address strobe |
| ctrlStrobeN | input | 1 | Second active-low address strobe |
| loadQualify | input | 1 | High when a strobe may be accepted as a load |
| advanceN | input | 1 | Active-low burst advance |
| orderSel | input | 1 | Static: 1 selects interleaved order, 0 selects linear |
| addrIn | input | ADDR_W | External start address |
| addrOut | output | ADDR_W | Registered burst word address |
| beatKind | output | 2 | 0 idle, 1 loaded, 2 advanced, 3 held |

## Verification
Both outputs respond to the sampling edge with exactly one register of delay. An address or kind that results from the inputs seen at edge n is visible after edge n and stays until edge n+1. The bench changes inputs on the falling edge and reads the outputs 2 ns after each rising edge. A bench model updated once per rising edge supplies the expected value for that same window, so no extra pipeline stage has to be accounted for. The sweep covers both orders, all four start offsets, both strobes and several upper-address values. In each burst, loads are made with advance held low, holds are inserted, the beat index wraps past four, and unqualified strobes are applied.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    KIND_IDLE = 2'd0,
    KIND_LOAD = 2'd1,
    KIND_STEP = 2'd2,
    KIND_HOLD = 2'd3
  } beatKind_e;

  typedef struct packed {
    logic load;
    logic step;
  } seqCtrl_t;

  localparam int unsigned LOW_W = 2;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      procStrobeN,
  input  logic      ctrlStrobeN,
  input  logic      loadQualify,
  input  logic      advanceN,
  output seqCtrl_t  ctrl,
  output beatKind_e kind
);
  logic active;

  // A qualified strobe wins over advance on the same edge (R4).
  always_comb begin
    ctrl.load = loadQualify & (~procStrobeN | ~ctrlStrobeN);
    ctrl.step = ~ctrl.load & active & ~advanceN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      kind   <= KIND_IDLE;
    end else begin
      active <= active | ctrl.load;
      if (ctrl.load)      kind <= KIND_LOAD;
      else if (ctrl.step) kind <= KIND_STEP;
      else if (active)    kind <= KIND_HOLD;
      else                kind <= KIND_IDLE;
    end
  end
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtrl_t          ctrl,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int unsigned UP_W = ADDR_W - LOW_W;

  logic [LOW_W-1:0] baseLow;
  logic [LOW_W-1:0] beatIdx;
  logic [LOW_W-1:0] nextIdx;
  logic [LOW_W-1:0] nextLow;
  logic [UP_W-1:0]  upperReg;
  logic [LOW_W-1:0] lowReg;

  // The index wraps modulo four, so nothing carries into the upper bits.
  always_comb begin
    nextIdx = beatIdx + 1'b1;
    nextLow = orderSel ? (baseLow ^ nextIdx) : (baseLow + nextIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseLow  <= '0;
      beatIdx  <= '0;
      upperReg <= '0;
      lowReg   <= '0;
    end else if (ctrl.load) begin
      baseLow  <= addrIn[LOW_W-1:0];
      beatIdx  <= '0;
      upperReg <= addrIn[ADDR_W-1:LOW_W];
      lowReg   <= addrIn[LOW_W-1:0];
    end else if (ctrl.step) begin
      beatIdx  <= nextIdx;
      lowReg   <= nextLow;
    end
  end

  assign addrOut = {upperReg, lowReg};
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              loadQualify,
  input  logic              advanceN,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [1:0]        beatKind
);
  seqCtrl_t  ctrl;
  beatKind_e kind;

  burst_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .loadQualify (loadQualify),
    .advanceN    (advanceN),
    .ctrl        (ctrl),
    .kind        (kind)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .orderSel (orderSel),
    .addrIn   (addrIn),
    .addrOut  (addrOut)
  );

  assign beatKind = kind;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              loadQualify,
  input logic              advanceN,
  input logic              orderSel,
  input logic [ADDR_W-1:0] addrIn,
  input logic [ADDR_W-1:0] addrOut,
  input logic [1:0]        beatKind
);
  logic loadSeen;
  assign loadSeen = loadQualify && (!procStrobeN || !ctrlStrobeN);

  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rstN)
    loadSeen |=> (addrOut == $past(addrIn)) && (beatKind == 2'd1));

  a_r9_idle_until_load: assert property (@(posedge clk) disable iff (!rstN)
    (beatKind == 2'd0 && !loadSeen) |=> (beatKind == 2'd0) && (addrOut == '0));

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (beatKind != 2'd0 && !loadSeen && advanceN) |=> $stable(addrOut) && (beatKind == 2'd3));

  a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rstN)
    !loadSeen |=> $stable(addrOut[ADDR_W-1:2]));

  a_r6_linear_step: assert property (@(posedge clk) disable iff (!rstN)
    (beatKind != 2'd0 && !loadSeen && !advanceN && !orderSel)
      |=> (addrOut[1:0] == 2'($past(addrOut[1:0]) + 2'd1)) && (beatKind == 2'd2));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .procStrobeN (procStrobeN),
  .ctrlStrobeN (ctrlStrobeN),
  .loadQualify (loadQualify),
  .advanceN    (advanceN),
  .orderSel    (orderSel),
  .addrIn      (addrIn),
  .addrOut     (addrOut),
  .beatKind    (beatKind)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int unsigned ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              procStrobeN = 1'b1;
  logic              ctrlStrobeN = 1'b1;
  logic              loadQualify = 1'b0;
  logic              advanceN = 1'b1;
  logic              orderSel = 1'b1;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [ADDR_W-1:0] addrOut;
  logic [1:0]        beatKind;

  int checks = 0;
  int failures = 0;

  // Bench model of the expected outputs
  logic              mActive = 1'b0;
  logic [1:0]        mBase = '0;
  logic [1:0]        mIdx = '0;
  logic [1:0]        mLow = '0;
  logic [ADDR_W-3:0] mUp = '0;
  logic [1:0]        mKind = '0;
  int                stepsSinceLoad = 0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .loadQualify(loadQualify), .advanceN(advanceN), .orderSel(orderSel),
    .addrIn(addrIn), .addrOut(addrOut), .beatKind(beatKind)
  );

  task automatic check(input string tag, input logic [ADDR_W-1:0] expA, input logic [1:0] expK);
    checks++;
    if (addrOut !== expA) begin
      failures++;
      $display("FAIL %s addrOut actual=%h expected=%h", tag, addrOut, expA);
    end
    checks++;
    if (beatKind !== expK) begin
      failures++;
      $display("FAIL %s beatKind actual=%0d expected=%0d", tag, beatKind, expK);
    end
  endtask

  // One cycle: drive on falling edge, model at rising edge, sample 2 ns later.
  task automatic cycle(input logic p, input logic c, input logic q, input logic adv,
                       input logic [ADDR_W-1:0] a, input string tag);
    logic ld;
    @(negedge clk);
    procStrobeN = p; ctrlStrobeN = c; loadQualify = q; advanceN = adv; addrIn = a;
    ld = q && (!p || !c);
    @(posedge clk);
    if (ld) begin
      mBase = a[1:0]; mIdx = 2'd0; mLow = a[1:0]; mUp = a[ADDR_W-1:2];
      mActive = 1'b1; mKind = 2'd1; stepsSinceLoad = 0;
    end else if (mActive && !adv) begin
      mIdx = mIdx + 2'd1;
      mLow = orderSel ? (mBase ^ mIdx) : 2'(mBase + mIdx);
      mKind = 2'd2; stepsSinceLoad++;
    end else if (mActive) begin
      mKind = 2'd3;
    end else begin
      mKind = 2'd0;
    end
    #2;
    check(tag, mActive ? {mUp, mLow} : '0, mKind);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    #2;
    check("R1 in reset", '0, 2'd0);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    // R9: advance before any load does nothing; R3: unqualified strobe ignored
    for (int i = 0; i < 3; i++) cycle(1, 1, 1, 0, 16'hFFFF, "R9 advance before load");
    cycle(0, 0, 0, 0, 16'h1234, "R3 unqualified strobe idle");
    for (int mode = 0; mode < 2; mode++) begin
      orderSel = mode[0];
      for (int base = 0; base < 4; base++) begin
        for (int u = 0; u < 2; u++) begin
          logic [ADDR_W-1:0] a;
          a = {(u == 0) ? 14'h3FFF : 14'(base * 901 + 5), 2'(base)};
          // R2, R4: load with advance low, alternating strobes
          if (u == 0) cycle(0, 1, 1, 0, a, "R4 proc strobe load ignores advance");
          else        cycle(1, 0, 1, 0, a, "R2 ctrl strobe load");
          cycle(1, 1, 1, 0, ~a, mode ? "R5 interleaved beat" : "R6 linear beat");
          cycle(1, 1, 1, 1, ~a, "R7 hold");
          cycle(1, 1, 1, 1, ~a, "R7 hold again");
          for (int s = 0; s < 5; s++)
            cycle(1, 1, 1, 0, ~a, mode ? "R5 R8 interleaved wrap" : "R6 R8 linear wrap");
          cycle(0, 1, 0, 0, ~a, "R3 unqualified strobe steps");
          cycle(1, 0, 0, 1, ~a, "R3 unqualified strobe holds");
        end
      end
    end
    // back-to-back loads
    cycle(0, 0, 1, 0, 16'hA5A6, "R2 both strobes");
    cycle(1, 0, 1, 0, 16'h0003, "R2 reload");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule